// File: doc/BRIEF.md
# Shadow-Sampled Timing-Error Correcting Register Bank

This block is a bank of register bits that can notice when its own input arrived too late and repair itself. Every bit holds two samples of the same input. The main flop takes its sample on the rising clock edge. A shadow stage stays open through the high phase and closes on the falling edge, so it takes a second, later sample. If a data transition lands after the rising edge but before the falling edge, the two samples disagree. The bit then raises an error in the low phase. The same error can also be raised by a per-bit metastability flag, which stands in for an analog detector and is sampled at the end of the high phase.

All bit errors are OR-combined into one bank restore output. On the next rising edge the bank copies the shadow sample into the main flop, so the late value appears at the output one cycle after the fault. The input offered on that correcting edge is dropped, so the surrounding pipeline uses the restore output to stall or replay. Through the high phase that follows a correction, the shadow stage is held closed. The error state is also cleared at that falling edge, so one fault gives a restore pulse exactly one clock period long. A restore input lets a neighbouring bank order the same write-back without any local error.

The shadow stage is modelled as a falling-edge register, which holds the value a transparent latch would have at the moment it closes. Reset is asynchronous and active low. Its release is synchronised to the rising edge.

Top module: `shadow_reg_bank`

## Requirements
- R1: While reset is asserted, and for the synchroniser stages after its release, q_o, err_o and restore_o are all zero.
- R2: When d_i is stable across the high phase and no metastability flag is set, q_o shows the value d_i had at the rising edge from that edge onward, and no error bit is raised at the following falling edge.
- R3: A bit of d_i that changes after the rising edge and before the falling edge raises the matching err_o bit in the low phase that follows. Bits that did not change stay zero.
- R4: restore_o is high exactly while at least one err_o bit is high. It is zero whenever err_o is all zeros.
- R5: On a rising edge where restore_o or restore_i is high, the main flop loads the shadow sample. q_o then equals the value d_i had at the previous falling edge, and the d_i value offered at that rising edge is discarded.
- R6: At the falling edge after a correcting rising edge, every error bit is cleared, whatever d_i and meta_i are doing. A restore_o pulse seen at one rising edge is therefore gone by the next rising edge.
- R7: d_i changes during the high phase after a correcting rising edge do not enter the shadow. A restore_i on the next rising edge reloads q_o with the earlier shadow value.
- R8: A meta_i bit that is high at a falling edge with no correction pending sets the matching err_o bit in the following low phase, even when the two samples agree. The following correction leaves q_o at the shadow value.
- R9: restore_i alone, with no local error, performs the write-back of R5 and raises neither err_o nor restore_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; rising edge loads the main flops, falling edge closes the shadow samples |
| rst_n | input | 1 | Asynchronous active-low reset, release synchronised internally |
| d_i | input | WIDTH | Data to be registered |
| meta_i | input | WIDTH | Per-bit metastability flag, sampled at the falling edge |
| restore_i | input | 1 | Write-back order from outside the bank, sampled at the rising edge |
| q_o | output | WIDTH | Registered data |
| err_o | output | WIDTH | Per-bit error, valid from the falling edge for one clock period |
| restore_o | output | 1 | OR of all error bits |

## Verification
A wrong shadow sample shows up at the falling edge, because it raises err_o against a q_o that the bench predicts to be clean. It shows up again at the next rising edge, when the write-back loads a value other than the one d_i had when the high phase ended. A hold flag that sets too late or clears too early shows within a single clock period, as a restore_o pulse that lasts two periods, or as a q_o after restore_i that carries a high-phase change. Every half period the bench compares q_o, err_o and restore_o with a reference model, so any difference is reported at the edge where it first appears.

// File: rtl/shadow_reg_pkg.sv
`timescale 1ns/1ps
package shadow_reg_pkg;

  // default depth of the reset release synchroniser
  localparam int unsigned SR_SYNC_STAGES = 2;

  // per-bit state exposed by one storage cell to the bank
  typedef struct packed {
    logic main;    // rising-edge sample, after any write-back
    logic shadow;  // sample taken as the high phase closes
    logic err;     // mismatch or metastability, held for one period
  } sr_cell_obs_t;

endpackage

// File: rtl/sr_reset_sync.sv
`timescale 1ns/1ps
module sr_reset_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_nxt;

  always_comb begin
    chain_nxt    = chain_q << 1;
    chain_nxt[0] = 1'b1;
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_nxt;
  end

  assign srst_n = chain_q[STAGES-1];

endmodule

// File: rtl/sr_bit_cell.sv
`timescale 1ns/1ps
module sr_bit_cell
  import shadow_reg_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         d,
  input  logic         meta,
  input  logic         restore,  // write-back order for this rising edge
  input  logic         hold,     // a write-back happened at the last rising edge
  output sr_cell_obs_t obs
);

  logic main_q, main_nxt;
  logic shadow_q, shadow_nxt, shadow_en;
  logic err_q, err_nxt;

  // main stage: the late sample replaces the input when restoring
  always_comb begin
    main_nxt = restore ? shadow_q : d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) main_q <= 1'b0;
    else        main_q <= main_nxt;
  end

  // shadow stage: closes at the falling edge, stays shut after a write-back
  always_comb begin
    shadow_en  = !hold;
    shadow_nxt = shadow_en ? d : shadow_q;
    // detection re-armed while holding, so one fault gives one pulse
    err_nxt    = hold ? 1'b0 : ((main_q ^ d) | meta);
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      shadow_q <= shadow_nxt;
      err_q    <= err_nxt;
    end
  end

  assign obs.main   = main_q;
  assign obs.shadow = shadow_q;
  assign obs.err    = err_q;

endmodule

// File: rtl/sr_restore_tree.sv
`timescale 1ns/1ps
module sr_restore_tree #(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0] err_i,
  output logic             any_o
);

  always_comb begin
    any_o = 1'b0;
    for (int i = 0; i < WIDTH; i++) any_o = any_o | err_i[i];
  end

endmodule

// File: rtl/shadow_reg_bank.sv
`timescale 1ns/1ps
module shadow_reg_bank
  import shadow_reg_pkg::*;
#(
  parameter int unsigned WIDTH       = 8,
  parameter int unsigned SYNC_STAGES = SR_SYNC_STAGES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  input  logic [WIDTH-1:0] meta_i,
  input  logic             restore_i,
  output logic [WIDTH-1:0] q_o,
  output logic [WIDTH-1:0] err_o,
  output logic             restore_o
);

  logic             srst_n;
  logic [WIDTH-1:0] main_vec;
  logic [WIDTH-1:0] shadow_vec;
  logic [WIDTH-1:0] err_vec;
  logic             local_restore;
  logic             restore_eff;
  logic             hold_q, hold_nxt;

  sr_reset_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  for (genvar b = 0; b < WIDTH; b++) begin : g_cell
    sr_cell_obs_t obs_b;
    sr_bit_cell u_cell (
      .clk     (clk),
      .rst_n   (srst_n),
      .d       (d_i[b]),
      .meta    (meta_i[b]),
      .restore (restore_eff),
      .hold    (hold_q),
      .obs     (obs_b)
    );
    assign main_vec[b]   = obs_b.main;
    assign shadow_vec[b] = obs_b.shadow;
    assign err_vec[b]    = obs_b.err;
  end

  sr_restore_tree #(.WIDTH(WIDTH)) u_or (
    .err_i (err_vec),
    .any_o (local_restore)
  );

  always_comb begin
    restore_eff = restore_i | local_restore;
    hold_nxt    = restore_eff;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) hold_q <= 1'b0;
    else         hold_q <= hold_nxt;
  end

  assign q_o       = main_vec;
  assign err_o     = err_vec;
  assign restore_o = local_restore;

endmodule

// File: rtl/shadow_reg_chk.sv
`timescale 1ns/1ps
module shadow_reg_chk #(
  parameter int unsigned WIDTH = 8
) (
  input logic             clk,
  input logic             srst_n,
  input logic [WIDTH-1:0] d_i,
  input logic [WIDTH-1:0] meta_i,
  input logic             restore_i,
  input logic [WIDTH-1:0] q_o,
  input logic [WIDTH-1:0] err_o,
  input logic             restore_o,
  input logic [WIDTH-1:0] shadow_w,
  input logic             hold_w
);

  // R1
  always_comb begin
    if (!srst_n) begin
      rst_clear_chk: assert (q_o == '0 && err_o == '0 && !restore_o);
    end
  end

  // R2
  quiet_bit_chk: assert property (@(negedge clk) disable iff (!srst_n)
    (!hold_w && q_o == d_i && meta_i == '0) |=> (err_o == '0));

  // R3
  late_edge_chk: assert property (@(negedge clk) disable iff (!srst_n)
    (!hold_w && q_o != d_i) |=> (err_o != '0));

  // R4
  idle_restore_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (err_o == '0) |-> !restore_o);

  // R5
  writeback_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (restore_i || restore_o) |=> (q_o == $past(shadow_w)));

  // R6
  single_pulse_chk: assert property (@(posedge clk) disable iff (!srst_n)
    restore_o |=> !restore_o);

  // R7
  shadow_hold_chk: assert property (@(negedge clk) disable iff (!srst_n)
    hold_w |=> $stable(shadow_w));

  // R8
  meta_flag_chk: assert property (@(negedge clk) disable iff (!srst_n)
    (!hold_w && meta_i != '0) |=> ((err_o & $past(meta_i)) == $past(meta_i)));

  // R9
  ext_restore_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (restore_i && !restore_o) |=> !restore_o);

endmodule

bind shadow_reg_bank shadow_reg_chk #(.WIDTH(WIDTH)) u_chk (
  .clk       (clk),
  .srst_n    (srst_n),
  .d_i       (d_i),
  .meta_i    (meta_i),
  .restore_i (restore_i),
  .q_o       (q_o),
  .err_o     (err_o),
  .restore_o (restore_o),
  .shadow_w  (shadow_vec),
  .hold_w    (hold_q)
);

// File: tb/sim_shadow_reg_bank.sv
`timescale 1ns/1ps
module sim_shadow_reg_bank;

  localparam int W = 8;

  logic         clk;
  logic         rst_n;
  logic [W-1:0] d;
  logic [W-1:0] meta;
  logic         rin;
  logic [W-1:0] q;
  logic [W-1:0] err;
  logic         rout;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // reference state
  logic [W-1:0] e_q, e_sh, e_err;
  logic         e_hold;

  shadow_reg_bank #(.WIDTH(W)) u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .d_i       (d),
    .meta_i    (meta),
    .restore_i (rin),
    .q_o       (q),
    .err_o     (err),
    .restore_o (rout)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string tag, input string what,
                     input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic void model_rise(input logic [W-1:0] din, input logic ri);
    logic reff;
    reff   = ri | (|e_err);
    e_q    = reff ? e_sh : din;
    e_hold = reff;
  endfunction

  function automatic void model_fall(input logic [W-1:0] din, input logic [W-1:0] m);
    if (e_hold) e_err = '0;
    else begin
      e_sh  = din;
      e_err = (e_q ^ din) | m;
    end
  endfunction

  // one clock period, entered and left in the low phase
  task automatic run_cycle(input logic [W-1:0] de, input logic [W-1:0] dl,
                           input logic [W-1:0] m, input logic ri, input string qtag);
    string tq, te;
    logic  had_err;
    had_err = |e_err;
    d = de; rin = ri; meta = '0;
    @(posedge clk);
    model_rise(de, ri);
    #1;
    if (qtag != "") tq = qtag;
    else if (had_err) tq = "R5";
    else if (ri) tq = "R9";
    else tq = "R2";
    chk(tq, "q_o", q, e_q);
    d = dl; meta = m; rin = 1'b0;
    @(negedge clk);
    model_fall(dl, m);
    #1;
    if (e_hold) te = "R6";
    else if (m != '0) te = "R8";
    else if (dl != de) te = "R3";
    else te = "R2";
    chk(te, "err_o", err, e_err);
    chk("R4", "restore_o", {{(W-1){1'b0}}, rout}, {{(W-1){1'b0}}, |e_err});
    meta = '0;
  endtask

  initial begin
    #800000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] a, late, msk;
    void'($urandom(32'd20250611));
    rst_n = 1'b0; d = 8'h5A; meta = 8'hFF; rin = 1'b1;
    e_q = '0; e_sh = '0; e_err = '0; e_hold = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    // R1 during reset, with busy inputs
    chk("R1", "q_o in reset", q, '0);
    chk("R1", "err_o in reset", err, '0);
    chk("R1", "restore_o in reset", {{(W-1){1'b0}}, rout}, '0);
    d = '0; meta = '0; rin = 1'b0;
    @(posedge clk); #0.5 rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    chk("R1", "q_o after release", q, '0);
    chk("R1", "err_o after release", err, '0);

    // R2 plain capture
    run_cycle(8'hA5, 8'hA5, '0, 1'b0, "R2");
    run_cycle(8'h3C, 8'h3C, '0, 1'b0, "R2");
    // R3 single late bit, then R5 correction discards 8'h77
    run_cycle(8'h3C, 8'h3D, '0, 1'b0, "R2");
    run_cycle(8'h77, 8'h77, '0, 1'b0, "R5");
    chk("R5", "q_o after correction", q, 8'h3D);
    run_cycle(8'h77, 8'h77, '0, 1'b0, "R2");
    // R3 several late bits
    run_cycle(8'h00, 8'h81, '0, 1'b0, "R2");
    chk("R3", "err_o multi-bit", err, 8'h81);
    run_cycle(8'h10, 8'h10, '0, 1'b0, "R5");
    // R8 metastability flag with matching samples
    run_cycle(8'h10, 8'h10, 8'h04, 1'b0, "R2");
    chk("R8", "err_o meta", err, 8'h04);
    run_cycle(8'hEE, 8'hEE, '0, 1'b0, "R8");
    chk("R8", "q_o after meta restore", q, 8'h10);
    run_cycle(8'hEE, 8'hEE, '0, 1'b0, "R2");
    // R6 masking and R7 shadow hold
    run_cycle(8'h40, 8'h42, '0, 1'b0, "R2");
    run_cycle(8'h99, 8'hC3, 8'hFF, 1'b0, "R5");
    chk("R6", "err_o masked after correction", err, '0);
    run_cycle(8'h55, 8'h55, '0, 1'b1, "R7");
    chk("R7", "q_o keeps held shadow", q, 8'h42);
    run_cycle(8'h55, 8'h55, '0, 1'b0, "R2");
    // R9 external restore only
    run_cycle(8'h6B, 8'h6B, '0, 1'b0, "R2");
    run_cycle(8'h12, 8'h12, '0, 1'b1, "R9");
    chk("R9", "q_o from external restore", q, 8'h6B);
    chk("R9", "restore_o stays low", {{(W-1){1'b0}}, rout}, '0);
    run_cycle(8'h12, 8'h12, '0, 1'b0, "R2");

    // constrained random traffic
    for (int i = 0; i < 300; i++) begin
      a    = W'($urandom);
      late = (($urandom % 4) == 0) ? (W'(1) << ($urandom % W)) : '0;
      if (($urandom % 16) == 0) late = late | W'($urandom);
      msk  = (($urandom % 16) == 0) ? (W'(1) << ($urandom % W)) : '0;
      run_cycle(a, a ^ late, msk, (($urandom % 12) == 0), "");
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule